// File: doc/BRIEF.md
# Partial Reconfiguration Handshake Sequencer

This block drives the control lines of a programmable fabric through the complete handshake for loading a partial reconfiguration image. A start command makes it check the fabric's status first: the fabric must be in user mode, and the mode-select field must name a passive scheme. It then forces the configuration format, brings the control lines up one at a time in a fixed order, and asks a separate clock-burst block for bursts of configuration clocks between phases. Once the fabric reports that it is ready, the block raises a ready-for-data flag. The bitstream itself moves on a path outside this block, and the block waits for the data-stream-complete indication.

After the data phase it waits for the fabric to report that the partial load is done. It then releases the request, runs one more clock burst and brings the control lines down in a fixed order. Last, it checks the user-mode, config-done and status pins. Every way the handshake can fail has its own status code. That code stays on the status output until the next accepted start. When the block aborts, the control lines stay where they were at that point, so the failed state can be inspected.

Top module: `pr_seq_top`

## Requirements
- R1: After reset the outputs are in this state. prRequest=0, chipEnN=1, cfgCtrlEn=0, statusPinOe=1, enableCfgN=1, nConfig=1. cdRatio equals the RESET_RATIO parameter (default 3) and cfgWidth32=1. burstReq=0, busy=0, readyForData=0 and statusCode=0 (no result).
- R2: When start is accepted while userMode is low, the block ends with statusCode=2 and does not change any control line.
- R3: When start is accepted with userMode high but modeSel (3 bits) is neither 0 nor 1, the block ends with statusCode=3 and does not change any control line.
- R4: The setup changes the lines in this order, each step in its own later cycle. First cdRatio=0 with cfgWidth32=0. Then prRequest=0 with nConfig=1. Then chipEnN=0, then cfgCtrlEn=1, then statusPinOe=0, then enableCfgN=0.
- R5: After setup the block issues a one-cycle burstReq with burstLen=256. After burstDone it raises prRequest. It then issues a burst with burstLen=2047 and waits for burstDone again. Every burst request happens while chipEnN=0, cfgCtrlEn=1, enableCfgN=0 and statusPinOe=0.
- R6: After the long burst the block polls once per cycle, at most 10 times. prError aborts with statusCode=4, and it wins over a prReady seen in the same cycle. prReady enters the data phase. Ten polls with neither abort with statusCode=5, and busy falls 11 cycles after the cycle in which the last burstDone was high. In the data phase readyForData is high, with prRequest high, until dataDone is seen.
- R7: After the data phase the block polls for prDone. prError aborts with statusCode=6. Either prDone or 10 polls lets the block lower prRequest and issue a burst with burstLen=256.
- R8: After that burst completes, the teardown changes cfgCtrlEn to 0, then chipEnN to 1, then enableCfgN to 1.
- R9: The final check gives statusCode=1 when userMode, confDonePin and nStatusPin are all high. Otherwise the code is 8 (user mode lost), 9 (config-done low) or 10 (status pin low), checked in that priority.
- R10: If burstDone is not seen within BURST_TIMEOUT cycles of a burst request, the block aborts with statusCode=7. A burstDone in the last allowed cycle wins over the timeout.
- R11: An accepted start clears statusCode to 0. The result code then holds while the block is idle. A start while busy is ignored.
- R12: On any abort busy falls and every control line keeps the value it had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start command, accepted only while idle |
| dataDone | input | 1 | Image stream has been fully delivered |
| userMode | input | 1 | Fabric is in user mode |
| modeSel | input | 3 | Fabric mode-select field |
| prReady | input | 1 | Fabric ready for partial image |
| prDone | input | 1 | Fabric finished the partial load |
| prError | input | 1 | Fabric reports a partial load error |
| confDonePin | input | 1 | Config-done pin level |
| nStatusPin | input | 1 | Status pin level (low means fault) |
| burstDone | input | 1 | Clock-burst block finished the requested burst |
| burstReq | output | 1 | One-cycle request for a clock burst |
| burstLen | output | LEN_W | Number of clocks in the requested burst |
| prRequest | output | 1 | Partial reconfiguration request |
| chipEnN | output | 1 | Chip enable, active low |
| cfgCtrlEn | output | 1 | Configuration control enable |
| enableCfgN | output | 1 | Enable configuration, active low |
| nConfig | output | 1 | Full-configuration line, held high |
| statusPinOe | output | 1 | Output enable of the config-done and status pins |
| cdRatio | output | 2 | Clock-to-data ratio selection |
| cfgWidth32 | output | 1 | 1 selects 32-bit configuration width, 0 selects 16-bit |
| busy | output | 1 | Sequence in progress |
| readyForData | output | 1 | Data phase open |
| statusCode | output | 4 | Result code of the last sequence |

## Verification
Two pairs of decisions can land on the same cycle. In a burst wait, the burst can complete in the very cycle the watchdog runs out. In the ready poll, prError and prReady can both be high. The bench sets its burst model's reply delay to BURST_TIMEOUT-1 and then to BURST_TIMEOUT. The first must give a full successful run, and the second must abort with code 7 right after the first burst. For the poll, the bench holds prError and prReady high together and expects code 4, with the control lines frozen at the end of setup.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;

  typedef enum logic [3:0] {
    ST_NONE     = 4'd0,
    ST_OK       = 4'd1,
    ST_MODE     = 4'd2,
    ST_MSEL     = 4'd3,
    ST_RDYERR   = 4'd4,
    ST_RDYTO    = 4'd5,
    ST_PRERR    = 4'd6,
    ST_BURSTTO  = 4'd7,
    ST_FINUSER  = 4'd8,
    ST_FINCDONE = 4'd9,
    ST_FINNSTAT = 4'd10
  } statusE;

  typedef enum logic [4:0] {
    P_IDLE, P_CHK, P_FMT, P_REQLO, P_CE, P_CCTL, P_OE, P_ENCFG,
    P_B1, P_W1, P_REQHI, P_B2, P_W2, P_POLLRDY, P_DATA, P_POLLDONE,
    P_REQOFF, P_B3, P_W3, P_CCOFF, P_CEOFF, P_ENOFF, P_FINAL
  } phaseE;

  typedef struct packed {
    logic   fmtSet;
    logic   reqLow;
    logic   ceLow;
    logic   cctlOn;
    logic   oeOff;
    logic   encfgLow;
    logic   reqHigh;
    logic   cctlOff;
    logic   ceHigh;
    logic   encfgHigh;
    logic   burstStart;
    logic   burstLong;
    logic   wdRun;
    logic   pollStep;
    logic   cntClr;
    logic   statusWr;
    statusE code;
  } strobeT;

endpackage

// File: rtl/pr_seq_ctrl.sv
module pr_seq_ctrl
  import pr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dataDone,
  input  logic       userMode,
  input  logic [2:0] modeSel,
  input  logic       prReady,
  input  logic       prDone,
  input  logic       prError,
  input  logic       confDonePin,
  input  logic       nStatusPin,
  input  logic       burstDone,
  input  logic       wdLast,
  input  logic       pollLast,
  output strobeT     stb,
  output logic       busy,
  output logic       readyForData
);

  phaseE curPh, nxtPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curPh <= P_IDLE;
    else       curPh <= nxtPh;
  end

  always_comb begin
    stb   = '0;
    nxtPh = curPh;
    case (curPh)
      P_IDLE: begin
        if (start) begin
          stb.statusWr = 1'b1;
          stb.code     = ST_NONE;
          nxtPh        = P_CHK;
        end
      end
      P_CHK: begin
        if (!userMode) begin
          stb.statusWr = 1'b1;
          stb.code     = ST_MODE;
          nxtPh        = P_IDLE;
        end else if (modeSel > 3'd1) begin
          stb.statusWr = 1'b1;
          stb.code     = ST_MSEL;
          nxtPh        = P_IDLE;
        end else begin
          nxtPh = P_FMT;
        end
      end
      P_FMT:   begin stb.fmtSet   = 1'b1; nxtPh = P_REQLO; end
      P_REQLO: begin stb.reqLow   = 1'b1; nxtPh = P_CE;    end
      P_CE:    begin stb.ceLow    = 1'b1; nxtPh = P_CCTL;  end
      P_CCTL:  begin stb.cctlOn   = 1'b1; nxtPh = P_OE;    end
      P_OE:    begin stb.oeOff    = 1'b1; nxtPh = P_ENCFG; end
      P_ENCFG: begin stb.encfgLow = 1'b1; nxtPh = P_B1;    end
      P_B1, P_B3: begin
        stb.burstStart = 1'b1;
        stb.cntClr     = 1'b1;
        nxtPh          = (curPh == P_B1) ? P_W1 : P_W3;
      end
      P_B2: begin
        stb.burstStart = 1'b1;
        stb.burstLong  = 1'b1;
        stb.cntClr     = 1'b1;
        nxtPh          = P_W2;
      end
      P_W1, P_W2, P_W3: begin
        stb.wdRun = 1'b1;
        if (burstDone) begin
          nxtPh = (curPh == P_W1) ? P_REQHI :
                  (curPh == P_W2) ? P_POLLRDY : P_CCOFF;
        end else if (wdLast) begin
          stb.statusWr = 1'b1;
          stb.code     = ST_BURSTTO;
          nxtPh        = P_IDLE;
        end
      end
      P_REQHI: begin stb.reqHigh = 1'b1; nxtPh = P_B2; end
      P_POLLRDY: begin
        if (prError) begin
          stb.statusWr = 1'b1;
          stb.code     = ST_RDYERR;
          nxtPh        = P_IDLE;
        end else if (prReady) begin
          nxtPh = P_DATA;
        end else if (pollLast) begin
          stb.statusWr = 1'b1;
          stb.code     = ST_RDYTO;
          nxtPh        = P_IDLE;
        end else begin
          stb.pollStep = 1'b1;
        end
      end
      P_DATA: begin
        stb.cntClr = 1'b1;
        if (dataDone) nxtPh = P_POLLDONE;
      end
      P_POLLDONE: begin
        if (prError) begin
          stb.statusWr = 1'b1;
          stb.code     = ST_PRERR;
          nxtPh        = P_IDLE;
        end else if (prDone || pollLast) begin
          nxtPh = P_REQOFF;
        end else begin
          stb.pollStep = 1'b1;
        end
      end
      P_REQOFF: begin stb.reqLow    = 1'b1; nxtPh = P_B3;    end
      P_CCOFF:  begin stb.cctlOff   = 1'b1; nxtPh = P_CEOFF; end
      P_CEOFF:  begin stb.ceHigh    = 1'b1; nxtPh = P_ENOFF; end
      P_ENOFF:  begin stb.encfgHigh = 1'b1; nxtPh = P_FINAL; end
      P_FINAL: begin
        stb.statusWr = 1'b1;
        stb.code     = !userMode    ? ST_FINUSER  :
                       !confDonePin ? ST_FINCDONE :
                       !nStatusPin  ? ST_FINNSTAT : ST_OK;
        nxtPh        = P_IDLE;
      end
      default: nxtPh = P_IDLE;
    endcase
  end

  assign busy         = (curPh != P_IDLE);
  assign readyForData = (curPh == P_DATA);

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (stb.statusWr || busy));

endmodule

// File: rtl/pr_seq_dp.sv
module pr_seq_dp
  import pr_seq_pkg::*;
#(
  parameter int BURST_TIMEOUT = 4096,
  parameter int POLL_LIMIT    = 10,
  parameter int SHORT_BURST   = 256,
  parameter int LONG_BURST    = 2047,
  parameter int LEN_W         = 12,
  parameter int WD_W          = 12,
  parameter int POLL_W        = 4,
  parameter logic [1:0] RESET_RATIO = 2'd3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  output logic             wdLast,
  output logic             pollLast,
  output logic             burstReq,
  output logic [LEN_W-1:0] burstLen,
  output logic             prRequest,
  output logic             chipEnN,
  output logic             cfgCtrlEn,
  output logic             enableCfgN,
  output logic             nConfig,
  output logic             statusPinOe,
  output logic [1:0]       cdRatio,
  output logic             cfgWidth32,
  output statusE           statusCode
);

  logic [WD_W-1:0]   wdCnt;
  logic [POLL_W-1:0] pollCnt;

  assign wdLast   = (wdCnt == WD_W'(BURST_TIMEOUT - 1));
  assign pollLast = (pollCnt == POLL_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prRequest   <= 1'b0;
      chipEnN     <= 1'b1;
      cfgCtrlEn   <= 1'b0;
      enableCfgN  <= 1'b1;
      nConfig     <= 1'b1;
      statusPinOe <= 1'b1;
      cdRatio     <= RESET_RATIO;
      cfgWidth32  <= 1'b1;
      burstReq    <= 1'b0;
      burstLen    <= '0;
      wdCnt       <= '0;
      pollCnt     <= '0;
      statusCode  <= ST_NONE;
    end else begin
      if (stb.fmtSet) begin
        cdRatio    <= 2'd0;
        cfgWidth32 <= 1'b0;
      end
      if (stb.reqLow) begin
        prRequest <= 1'b0;
        nConfig   <= 1'b1;
      end
      if (stb.reqHigh)   prRequest   <= 1'b1;
      if (stb.ceLow)     chipEnN     <= 1'b0;
      if (stb.ceHigh)    chipEnN     <= 1'b1;
      if (stb.cctlOn)    cfgCtrlEn   <= 1'b1;
      if (stb.cctlOff)   cfgCtrlEn   <= 1'b0;
      if (stb.oeOff)     statusPinOe <= 1'b0;
      if (stb.encfgLow)  enableCfgN  <= 1'b0;
      if (stb.encfgHigh) enableCfgN  <= 1'b1;

      burstReq <= stb.burstStart;
      if (stb.burstStart)
        burstLen <= stb.burstLong ? LEN_W'(LONG_BURST) : LEN_W'(SHORT_BURST);

      if (stb.cntClr) begin
        wdCnt   <= '0;
        pollCnt <= '0;
      end else begin
        if (stb.wdRun && !wdLast)      wdCnt   <= wdCnt + 1'b1;
        if (stb.pollStep && !pollLast) pollCnt <= pollCnt + 1'b1;
      end

      if (stb.statusWr) statusCode <= stb.code;
    end
  end

  // R5
  burst_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstReq |-> (!chipEnN && cfgCtrlEn && !enableCfgN && !statusPinOe));

  // R5
  burst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstReq |=> !burstReq);

  // R10
  wd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdCnt < WD_W'(BURST_TIMEOUT));

  // R6
  poll_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT));

endmodule

// File: rtl/pr_seq_top.sv
module pr_seq_top
  import pr_seq_pkg::*;
#(
  parameter int BURST_TIMEOUT = 4096,
  parameter int POLL_LIMIT    = 10,
  parameter int SHORT_BURST   = 256,
  parameter int LONG_BURST    = 2047,
  parameter int LEN_W         = 12,
  parameter logic [1:0] RESET_RATIO = 2'd3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dataDone,
  input  logic             userMode,
  input  logic [2:0]       modeSel,
  input  logic             prReady,
  input  logic             prDone,
  input  logic             prError,
  input  logic             confDonePin,
  input  logic             nStatusPin,
  input  logic             burstDone,
  output logic             burstReq,
  output logic [LEN_W-1:0] burstLen,
  output logic             prRequest,
  output logic             chipEnN,
  output logic             cfgCtrlEn,
  output logic             enableCfgN,
  output logic             nConfig,
  output logic             statusPinOe,
  output logic [1:0]       cdRatio,
  output logic             cfgWidth32,
  output logic             busy,
  output logic             readyForData,
  output logic [3:0]       statusCode
);

  localparam int WD_W   = (BURST_TIMEOUT > 1) ? $clog2(BURST_TIMEOUT) : 1;
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  strobeT stb;
  logic   wdLast, pollLast;
  statusE statusReg;

  pr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dataDone(dataDone),
    .userMode(userMode), .modeSel(modeSel), .prReady(prReady),
    .prDone(prDone), .prError(prError), .confDonePin(confDonePin),
    .nStatusPin(nStatusPin), .burstDone(burstDone), .wdLast(wdLast),
    .pollLast(pollLast), .stb(stb), .busy(busy),
    .readyForData(readyForData)
  );

  pr_seq_dp #(
    .BURST_TIMEOUT(BURST_TIMEOUT), .POLL_LIMIT(POLL_LIMIT),
    .SHORT_BURST(SHORT_BURST), .LONG_BURST(LONG_BURST), .LEN_W(LEN_W),
    .WD_W(WD_W), .POLL_W(POLL_W), .RESET_RATIO(RESET_RATIO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdLast(wdLast),
    .pollLast(pollLast), .burstReq(burstReq), .burstLen(burstLen),
    .prRequest(prRequest), .chipEnN(chipEnN), .cfgCtrlEn(cfgCtrlEn),
    .enableCfgN(enableCfgN), .nConfig(nConfig),
    .statusPinOe(statusPinOe), .cdRatio(cdRatio),
    .cfgWidth32(cfgWidth32), .statusCode(statusReg)
  );

  assign statusCode = statusReg;

  // R6
  data_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyForData |-> (prRequest && cfgCtrlEn && !chipEnN));

  // R4
  req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prRequest) |-> (!chipEnN && cfgCtrlEn && !enableCfgN &&
                          !statusPinOe && cdRatio == 2'd0 && !cfgWidth32));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(statusCode));

  // R12
  abort_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(prRequest) && $stable(chipEnN) &&
                           $stable(cfgCtrlEn) && $stable(enableCfgN)));

endmodule

// File: tb/pr_seq_top_test.sv
module pr_seq_top_test;

  localparam int TMO = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic start = 1'b0, dataDone = 1'b0, userMode = 1'b1;
  logic [2:0] modeSel = 3'd0;
  logic prReady = 1'b1, prDone = 1'b1, prError = 1'b0;
  logic confDonePin = 1'b1, nStatusPin = 1'b1, burstDone = 1'b0;
  logic burstReq, prRequest, chipEnN, cfgCtrlEn, enableCfgN, nConfig;
  logic statusPinOe, cfgWidth32, busy, readyForData;
  logic [11:0] burstLen;
  logic [1:0] cdRatio;
  logic [3:0] statusCode;

  pr_seq_top #(.BURST_TIMEOUT(TMO)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dataDone(dataDone),
    .userMode(userMode), .modeSel(modeSel), .prReady(prReady),
    .prDone(prDone), .prError(prError), .confDonePin(confDonePin),
    .nStatusPin(nStatusPin), .burstDone(burstDone), .burstReq(burstReq),
    .burstLen(burstLen), .prRequest(prRequest), .chipEnN(chipEnN),
    .cfgCtrlEn(cfgCtrlEn), .enableCfgN(enableCfgN), .nConfig(nConfig),
    .statusPinOe(statusPinOe), .cdRatio(cdRatio), .cfgWidth32(cfgWidth32),
    .busy(busy), .readyForData(readyForData), .statusCode(statusCode)
  );

  int checks = 0, failures = 0, cyc = 0, lastDoneCyc = 0, endCyc = 0;
  int burstDelay = 3;
  bit dataErr = 1'b0, dataDropUser = 1'b0, monOn = 1'b0, finished = 1'b0;
  string curReq = "R4";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: bit 12 marks a burst item, low bits carry the value
  logic [12:0] sbq[$];
  bit mPr = 0, mCe = 1, mCc = 0, mOe = 1, mEn = 1, mNc = 1, mW = 1;
  logic [1:0] mRt = 2'd3;
  logic [11:0] mLast = 12'h0;

  function automatic logic [11:0] portLines();
    return {3'b0, prRequest, chipEnN, cfgCtrlEn, statusPinOe, enableCfgN,
            nConfig, cdRatio, cfgWidth32};
  endfunction

  function automatic logic [11:0] modelLines();
    return {3'b0, mPr, mCe, mCc, mOe, mEn, mNc, mRt, mW};
  endfunction

  task automatic pushLines();
    logic [11:0] v;
    v = modelLines();
    if (v != mLast) begin
      sbq.push_back({1'b0, v});
      mLast = v;
    end
  endtask

  task automatic pushBurst(input int n);
    sbq.push_back({1'b1, 12'(n)});
  endtask

  // stage 1: through the short burst, stage 2: through the long burst
  task automatic expSetup(input int stage);
    mRt = 2'd0; mW = 1'b0; pushLines();
    mPr = 1'b0; mNc = 1'b1; pushLines();
    mCe = 1'b0; pushLines();
    mCc = 1'b1; pushLines();
    mOe = 1'b0; pushLines();
    mEn = 1'b0; pushLines();
    pushBurst(256);
    if (stage > 1) begin
      mPr = 1'b1; pushLines();
      pushBurst(2047);
    end
  endtask

  task automatic expTeardown();
    mPr = 1'b0; pushLines();
    pushBurst(256);
    mCc = 1'b0; pushLines();
    mCe = 1'b1; pushLines();
    mEn = 1'b1; pushLines();
  endtask

  // monitor
  logic [11:0] monPrev;
  always @(negedge clk) begin
    if (monOn) begin
      logic [11:0] cur;
      cur = portLines();
      if (cur != monPrev) begin
        if (sbq.size() == 0) chk(1'b0, {curReq, " unexpected line change"}, int'(cur), -1);
        else begin
          logic [12:0] e;
          e = sbq.pop_front();
          chk(e == {1'b0, cur}, {curReq, " line order"}, int'(cur), int'(e));
        end
        monPrev = cur;
      end
      if (burstReq) begin
        if (sbq.size() == 0) chk(1'b0, "R5 unexpected burst", int'(burstLen), -1);
        else begin
          logic [12:0] e;
          e = sbq.pop_front();
          chk(e == {1'b1, burstLen}, "R5 burst length/order", int'({1'b1, burstLen}), int'(e));
        end
      end
    end
  end

  // clock-burst block model
  initial begin
    forever begin
      @(negedge clk);
      if (burstReq) begin
        repeat (burstDelay) @(negedge clk);
        burstDone = 1'b1;
        lastDoneCyc = cyc;
        @(negedge clk);
        burstDone = 1'b0;
      end
    end
  end

  // data-phase model
  initial begin
    forever begin
      @(negedge clk);
      if (readyForData) begin
        chk(prRequest == 1'b1, "R6 prRequest in data phase", int'(prRequest), 1);
        if (dataErr) prError = 1'b1;
        if (dataDropUser) userMode = 1'b0;
        @(negedge clk);
        chk(readyForData == 1'b1, "R6 readyForData held", int'(readyForData), 1);
        dataDone = 1'b1;
        @(negedge clk);
        dataDone = 1'b0;
      end
    end
  end

  task automatic runSeq(input int midStartAt, input int expCode, input string req);
    int n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(statusCode == 4'd0, "R11 start clears code", int'(statusCode), 0);
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
      if (n == midStartAt) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    endCyc = cyc;
    chk(statusCode == 4'(expCode), {req, " status code"}, int'(statusCode), expCode);
    chk(sbq.size() == 0, {req, " sequence complete"}, sbq.size(), 0);
    chk(portLines() == mLast, "R12 lines frozen after end", int'(portLines()), int'(mLast));
    repeat (6) @(negedge clk);
    sbq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    mLast = modelLines();
    chk(portLines() == mLast, "R1 reset lines", int'(portLines()), int'(mLast));
    chk({burstReq, busy, readyForData} == 3'b000, "R1 reset flags",
        int'({burstReq, busy, readyForData}), 0);
    chk(statusCode == 4'd0, "R1 reset code", int'(statusCode), 0);
    monPrev = portLines();
    monOn = 1'b1;

    // R2 invalid mode
    curReq = "R2"; userMode = 1'b0;
    runSeq(0, 2, "R2");
    userMode = 1'b1;

    // R3 bad mode-select
    curReq = "R3"; modeSel = 3'd2;
    runSeq(0, 3, "R3");
    modeSel = 3'd7;
    runSeq(0, 3, "R3");

    // R4 R5 R8 R9 R11 full success with a start while busy
    curReq = "R4"; modeSel = 3'd0;
    expSetup(2); expTeardown();
    runSeq(30, 1, "R9");
    chk(statusCode == 4'd1, "R11 code holds while idle", int'(statusCode), 1);

    // second success with passive slow from the post-run line state
    curReq = "R8"; modeSel = 3'd1;
    expSetup(2); expTeardown();
    runSeq(0, 1, "R8");

    // R6 ready timeout and timing
    curReq = "R6"; prReady = 1'b0;
    expSetup(2);
    runSeq(0, 5, "R6");
    chk(endCyc - lastDoneCyc == 11, "R6 ten polls", endCyc - lastDoneCyc, 11);

    // R6 error and ready in the same poll
    prReady = 1'b1; prError = 1'b1;
    expSetup(2);
    runSeq(0, 4, "R6");
    prError = 1'b0;

    // R7 error during done poll
    curReq = "R7"; dataErr = 1'b1;
    expSetup(2);
    runSeq(0, 6, "R7");
    dataErr = 1'b0; prError = 1'b0;

    // R7 no done: proceeds after polls
    prDone = 1'b0;
    expSetup(2); expTeardown();
    runSeq(0, 1, "R7");
    prDone = 1'b1;

    // R9 final pin checks
    curReq = "R9"; confDonePin = 1'b0;
    expSetup(2); expTeardown();
    runSeq(0, 9, "R9");
    nStatusPin = 1'b0;
    expSetup(2); expTeardown();
    runSeq(0, 9, "R9");
    confDonePin = 1'b1;
    expSetup(2); expTeardown();
    runSeq(0, 10, "R9");
    nStatusPin = 1'b1; confDonePin = 1'b0; dataDropUser = 1'b1;
    expSetup(2); expTeardown();
    runSeq(0, 8, "R9");
    dataDropUser = 1'b0; userMode = 1'b1; confDonePin = 1'b1;

    // R10 burst done in the last allowed cycle, then one cycle late
    curReq = "R10"; burstDelay = TMO - 1;
    expSetup(2); expTeardown();
    runSeq(0, 1, "R10");
    burstDelay = TMO;
    expSetup(1);
    runSeq(0, 7, "R10");
    burstDelay = 3;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule